// File: doc/BRIEF.md
# Hardware Store Handshake Controller

This block arbitrates store requests for a battery-free SRAM/nonvolatile memory pair. The request line is shared and active low. Outside logic pulls it low to ask for a store, and the block pulls it low through an open-drain enable to signal that a store is running. The block keeps a dirty flag that records whether the SRAM has been written since the last store or recall. When a hardware or automatic request finds the SRAM clean, the store is skipped.

When the line falls, new writes are blocked at once. Reads and in-flight writes get a fixed grace window of `DELAY_CYC` cycles. After the window, the block does one of two things:
- It starts the store engine if the SRAM is dirty.
- It holds off all memory access until the line is released if the SRAM is clean.

A software store bypasses the dirty check and starts at once. After any store, the memory stays disabled until the line is seen high again. The store engine is modelled as a counter of `STORE_CYC` cycles.

Top module: `store_handshake_ctrl`

## Requirements
- R1: After reset, `line_pull_o`, `wr_inhibit_o`, `rd_inhibit_o` and `store_start_o` are all low, and the dirty flag is clear.
- R2: The dirty flag sets on `wr_strobe_i` only while the controller is idle or in its grace window. Writes in other phases are ignored. The flag clears when a store completes or on `recall_done_i`, and a recall wins over a write in the same cycle.
- R3: The line input passes through a two-stage synchronizer. `wr_inhibit_o` rises two cycles after the line falls. `rd_inhibit_o` stays low for the `DELAY_CYC`-cycle grace window. With the SRAM dirty, `store_start_o` pulses exactly `DELAY_CYC`+3 cycles after the line falls.
- R4: A line request that finds the SRAM clean at the end of the grace window starts no store and never pulls the line. It holds both inhibits high until the line is seen high again.
- R5: An `auto_store_i` pulse with the SRAM clean has no effect. With the SRAM dirty, `line_pull_o` rises on the next cycle and `store_start_o` pulses `DELAY_CYC`+1 cycles after the trigger.
- R6: A `sw_store_i` pulse in idle starts a store on the next cycle whatever the dirty flag says. In idle, priority is software trigger, then automatic trigger, then line request.
- R7: `line_pull_o` is held from the `store_start_o` cycle through store completion, for `STORE_CYC`+1 cycles in total.
- R8: When `line_pull_o` drops at the end of a store, both inhibits stay high. They fall three cycles after the line is high at the input, and not before.
- R9: Triggers that arrive outside idle are ignored, so each store gives exactly one `store_start_o` pulse.
- R10: A write strobe inside the grace window makes a request that began clean start a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_strobe_i | input | 1 | One SRAM write completed this cycle |
| auto_store_i | input | 1 | Automatic store trigger pulse |
| sw_store_i | input | 1 | Software store trigger pulse |
| recall_done_i | input | 1 | Recall completed pulse |
| line_i | input | 1 | Raw level of the shared request/busy line |
| line_pull_o | output | 1 | Open-drain enable; 1 drives the line low |
| wr_inhibit_o | output | 1 | Block new SRAM writes |
| rd_inhibit_o | output | 1 | Block SRAM reads and writes |
| store_start_o | output | 1 | One-cycle start to the store engine |

## Verification
A wrong dirty flag shows up on the next request as a missing or unwanted `store_start_o`. For a line request that happens at `DELAY_CYC`+3 cycles; for a software store it shows at once, in the pulse count. A stuck phase shows as `line_pull_o` held for the wrong number of cycles, or as inhibits that fall earlier or later than three cycles after the line rises. A synchronizer that is too short or too long moves every one of these edges by a whole cycle. The bench therefore samples at exact cycle offsets instead of waiting loosely.

// File: rtl/store_hs_pkg.sv
package store_hs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRACE,
    ST_HOLD,
    ST_STORE,
    ST_RELEASE
  } hs_state_e;
endpackage

// File: rtl/hs_line_sync.sv
module hs_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] sync_q;

  // reset to 1: the line idles high through its pull-up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], line_i};
  end

  assign line_o = sync_q[STAGES-1];
endmodule

// File: rtl/hs_dirty_flag.sv
module hs_dirty_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);
  logic dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dirty_q <= 1'b0;
    else if (clr_i) dirty_q <= 1'b0;
    else if (set_i) dirty_q <= 1'b1;
  end

  assign dirty_o = dirty_q;
endmodule

// File: rtl/hs_store_engine.sv
module hs_store_engine #(
  parameter int unsigned STORE_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(STORE_CYC + 1);
  localparam logic [CW-1:0] C_LAST = CW'(STORE_CYC - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == C_LAST) busy_q <= 1'b0;
      else                 cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == C_LAST);
endmodule

// File: rtl/store_handshake_ctrl.sv
module store_handshake_ctrl
  import store_hs_pkg::*;
#(
  parameter int unsigned DELAY_CYC   = 8,
  parameter int unsigned STORE_CYC   = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_strobe_i,
  input  logic auto_store_i,
  input  logic sw_store_i,
  input  logic recall_done_i,
  input  logic line_i,
  output logic line_pull_o,
  output logic wr_inhibit_o,
  output logic rd_inhibit_o,
  output logic store_start_o
);
  localparam int unsigned GW = $clog2(DELAY_CYC + 1);
  localparam logic [GW-1:0] G_LAST = GW'(DELAY_CYC - 1);

  hs_state_e     state_q, state_d;
  logic [GW-1:0] gcnt_q;
  logic          auto_q;
  logic          start_q;
  logic          line_s;
  logic          dirty_q;
  logic          eng_busy;
  logic          eng_done;
  logic          dirty_set;
  logic          dirty_clr;
  logic          grace_end;

  hs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .line_o (line_s)
  );

  assign dirty_set = wr_strobe_i && (state_q == ST_IDLE || state_q == ST_GRACE);
  assign dirty_clr = eng_done || recall_done_i;

  hs_dirty_flag u_dirty (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (dirty_set),
    .clr_i   (dirty_clr),
    .dirty_o (dirty_q)
  );

  hs_store_engine #(.STORE_CYC(STORE_CYC)) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_q),
    .busy_o  (eng_busy),
    .done_o  (eng_done)
  );

  assign grace_end = (gcnt_q == G_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (sw_store_i)                  state_d = ST_STORE;
        else if (auto_store_i && dirty_q) state_d = ST_GRACE;
        else if (!line_s)                state_d = ST_GRACE;
      end
      ST_GRACE: begin
        // a write finishing in the last grace cycle still counts
        if (grace_end) state_d = (dirty_q || wr_strobe_i) ? ST_STORE : ST_HOLD;
      end
      ST_HOLD:    if (line_s)   state_d = ST_IDLE;
      ST_STORE:   if (eng_done) state_d = ST_RELEASE;
      ST_RELEASE: if (line_s)   state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gcnt_q  <= '0;
      auto_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= (state_q != ST_STORE) && (state_d == ST_STORE);
      if (state_q != ST_GRACE) gcnt_q <= '0;
      else if (!grace_end)     gcnt_q <= gcnt_q + 1'b1;
      if (state_q == ST_IDLE)
        auto_q <= !sw_store_i && auto_store_i && dirty_q;
    end
  end

  assign line_pull_o   = (state_q == ST_STORE) || (state_q == ST_GRACE && auto_q);
  assign wr_inhibit_o  = (state_q != ST_IDLE) || !line_s;
  assign rd_inhibit_o  = (state_q == ST_HOLD) || (state_q == ST_STORE) ||
                         (state_q == ST_RELEASE);
  assign store_start_o = start_q;
endmodule

// File: rtl/hs_checker.sv
module hs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic sw_store_i,
  input logic wr_strobe_i,
  input logic line_pull_o,
  input logic wr_inhibit_o,
  input logic rd_inhibit_o,
  input logic store_start_o,
  input logic eng_busy_i,
  input logic eng_done_i,
  input logic dirty_i
);
  // R9
  p_single_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |=> !store_start_o);

  // R7
  p_pull_at_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |-> line_pull_o && rd_inhibit_o && wr_inhibit_o);

  p_pull_while_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_busy_i |-> line_pull_o);

  // R8
  p_hold_after_store_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(line_pull_o) |-> rd_inhibit_o && wr_inhibit_o);

  // R2
  p_clean_after_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_done_i |=> !dirty_i);

  // R4 / R6
  p_store_needs_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |-> $past(sw_store_i) || $past(dirty_i) || $past(wr_strobe_i));
endmodule

bind store_handshake_ctrl hs_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sw_store_i    (sw_store_i),
  .wr_strobe_i   (wr_strobe_i),
  .line_pull_o   (line_pull_o),
  .wr_inhibit_o  (wr_inhibit_o),
  .rd_inhibit_o  (rd_inhibit_o),
  .store_start_o (store_start_o),
  .eng_busy_i    (eng_busy),
  .eng_done_i    (eng_done),
  .dirty_i       (dirty_q)
);

// File: tb/store_handshake_ctrl_bench.sv
module store_handshake_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D = 6;
  localparam int S = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, auto_t = 1'b0, sw_t = 1'b0, recall = 1'b0, ext_low = 1'b0;
  logic line_pull, wr_inh, rd_inh, start;
  logic line;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line = ~(ext_low | line_pull);

  store_handshake_ctrl #(.DELAY_CYC(D), .STORE_CYC(S)) u_store_handshake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_strobe_i(wr), .auto_store_i(auto_t),
    .sw_store_i(sw_t), .recall_done_i(recall), .line_i(line),
    .line_pull_o(line_pull), .wr_inhibit_o(wr_inh), .rd_inhibit_o(rd_inh),
    .store_start_o(start)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_wr();
    wr = 1'b1; step(); wr = 1'b0;
  endtask

  // waits until the controller is fully idle again
  task automatic settle();
    for (int i = 0; i < 200; i++) begin
      if (!line_pull && !wr_inh && !rd_inh) break;
      step();
    end
    step();
  endtask

  // counts pull cycles starting at the current sample
  task automatic count_pull(output int n, output int starts);
    n = 0; starts = 0;
    for (int i = 0; i < 500; i++) begin
      if (!line_pull) break;
      if (start) starts++;
      n++;
      step();
    end
  endtask

  task automatic t_reset();
    chk(!line_pull && !wr_inh && !rd_inh && !start, "R1 reset outputs",
        {line_pull, wr_inh, rd_inh, start}, 0);
  endtask

  task automatic t_hw_clean();
    int pulls = 0, starts = 0;
    ext_low = 1'b1;
    for (int k = 1; k <= D + 8; k++) begin
      step();
      pulls += line_pull; starts += start;
      if (k == 2)     chk(wr_inh, "R3 wr blocked after sync", wr_inh, 1);
      if (k == D + 2) chk(!rd_inh, "R3 reads open in grace", rd_inh, 0);
      if (k == D + 3) chk(rd_inh, "R4 hold when clean", rd_inh, 1);
      if (k == D + 5) pulse_wr(); // R2: ignored in hold
    end
    chk(pulls == 0 && starts == 0, "R4 no pull no store", pulls + starts, 0);
    ext_low = 1'b0;
    step(); step();
    chk(rd_inh, "R4 held until line high", rd_inh, 1);
    step();
    chk(!rd_inh && !wr_inh, "R4 released", {rd_inh, wr_inh}, 0);
    settle();
  endtask

  task automatic t_hw_dirty(input bit write_in_grace, input bit hold_ext);
    int first = 0, n, st;
    if (!write_in_grace) pulse_wr();
    ext_low = 1'b1;
    for (int k = 1; k <= D + 6 && first == 0; k++) begin
      step();
      if (write_in_grace && k == 4) pulse_wr();
      if (start) first = k + ((write_in_grace && k >= 4) ? 1 : 0);
    end
    if (write_in_grace)
      chk(first == D + 3, "R10 grace write starts store", first, D + 3);
    else
      chk(first == D + 3, "R3 store start delay", first, D + 3);
    if (!hold_ext) ext_low = 1'b0;
    count_pull(n, st);
    chk(n == S + 1, "R7 pull length", n, S + 1);
    chk(rd_inh && wr_inh, "R8 disabled after store", {rd_inh, wr_inh}, 3);
    if (hold_ext) begin
      repeat (8) step();
      chk(rd_inh, "R8 held while line low", rd_inh, 1);
      ext_low = 1'b0;
    end
    step(); step();
    chk(rd_inh, "R8 still held at sync", rd_inh, 1);
    step();
    chk(!rd_inh && !wr_inh, "R8 release after line high", {rd_inh, wr_inh}, 0);
    settle();
  endtask

  task automatic t_auto_clean();
    int seen = 0;
    auto_t = 1'b1; step(); auto_t = 1'b0;
    for (int k = 0; k < 6; k++) begin
      seen += line_pull + wr_inh + start;
      step();
    end
    chk(seen == 0, "R5 clean auto ignored", seen, 0);
  endtask

  task automatic t_auto_dirty();
    int first = 0, n, st;
    pulse_wr();
    auto_t = 1'b1; step(); auto_t = 1'b0;
    chk(line_pull, "R5 pull after auto", line_pull, 1);
    for (int k = 1; k <= D + 4 && first == 0; k++) begin
      if (start) first = k;
      if (first == 0) step();
    end
    chk(first == D + 1, "R5 auto start delay", first, D + 1);
    count_pull(n, st);
    chk(n == S + 1, "R7 auto pull length", n, S + 1);
    settle();
  endtask

  task automatic t_sw_always();
    int n, st, extra = 0;
    sw_t = 1'b1; step(); sw_t = 1'b0;
    chk(start, "R6 sw store while clean", start, 1);
    fork
      count_pull(n, st);
      begin
        step(); step(); step();
        sw_t = 1'b1; auto_t = 1'b1; wr = 1'b1; step();
        sw_t = 1'b0; auto_t = 1'b0; wr = 1'b0;
      end
    join
    chk(st == 1, "R9 one start per store", st, 1);
    chk(n == S + 1, "R7 sw pull length", n, S + 1);
    for (int k = 0; k < 8; k++) begin
      extra += start;
      step();
    end
    chk(extra == 0, "R9 no late start", extra, 0);
    settle();
    // write during store was ignored: line request must not store (R2)
    t_hw_clean();
  endtask

  task automatic t_recall(input bit same_cycle);
    int starts = 0;
    if (same_cycle) begin
      wr = 1'b1; recall = 1'b1; step(); wr = 1'b0; recall = 1'b0;
    end else begin
      pulse_wr();
      recall = 1'b1; step(); recall = 1'b0;
    end
    ext_low = 1'b1;
    for (int k = 0; k < D + 6; k++) begin
      step();
      starts += start;
    end
    chk(starts == 0, "R2 recall clears dirty", starts, 0);
    ext_low = 1'b0;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step();
    t_reset();
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_hw_clean();
    t_hw_dirty(1'b0, 1'b0);
    t_hw_clean();          // R2: completed store cleared the flag
    t_hw_dirty(1'b1, 1'b0);
    t_hw_dirty(1'b0, 1'b1);
    t_auto_clean();
    t_auto_dirty();
    t_sw_always();
    t_recall(1'b0);
    t_recall(1'b1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule